// File: doc/BRIEF.md
# Serial Audio Input Receiver

This block takes in a stereo stream of 16-bit audio words as a clock slave. The bit clock, the frame clock and the data line all come from outside. The block brings all three into its own system clock domain. It samples the data line on each rising edge of the bit clock and uses the frame clock level to tell the two channels apart.

The bit clock may run at any rate of at least 32 times the sample rate, so a half-frame can hold more bit periods than the word needs. A mode input says where the 16-bit word sits inside each half-frame:

- **Forward packed:** the word occupies the first sixteen bit periods.
- **Backward packed:** the word occupies the last sixteen bit periods.

When a frame is complete, the block presents the left and right samples together on parallel outputs, with a one-cycle valid strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: A synchronous reset drives `validOut` low and clears `leftOut` and `rightOut` to zero. A reset in mid-stream also clears them.
- R2: Each word is 16 bits and is sent MSB first. The first valid bit period carries bit 15.
- R3: A half-frame during which the frame clock is high carries the left sample. A half-frame during which it is low carries the right sample. The left half-frame comes first in a frame.
- R4: With `modeFwd` low (backward packed), the sample is the last 16 bits of its half-frame. The bits before them have no effect on the outputs.
- R5: With `modeFwd` high (forward packed), the sample is the first 16 bits of its half-frame. The bits after them have no effect on the outputs.
- R6: Any half-frame length of 16 bit periods or more is accepted. This covers 32, 48 and 64 bit periods per frame.
- R7: `validOut` is high for exactly one system clock cycle per frame, after the right word completes.
  - When it rises, `leftOut` and `rightOut` carry that frame's pair.
  - Both outputs hold their values until the next pulse.
  - Forward mode pulses during the right half-frame.
  - Backward mode pulses once the frame clock has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bitClkIn | input | 1 | External bit clock; data is taken on its rising edge |
| frameClkIn | input | 1 | External frame clock at the sample rate; high = left, low = right |
| dataIn | input | 1 | Serial audio data, MSB first |
| modeFwd | input | 1 | Word alignment: 1 = first 16 bits of the half-frame, 0 = last 16 bits |
| leftOut | output | 16 | Left sample of the most recent complete frame |
| rightOut | output | 16 | Right sample of the most recent complete frame |
| validOut | output | 1 | One-cycle strobe marking a new sample pair |

## Verification
The bench fills every unused bit period with the bitwise inverse of the word. A receiver that counts the wrong bits in either packing mode therefore returns a visibly corrupted sample instead of a lucky match.

Frames are sent with 32, 48 and 64 bit periods. A design that assumes a fixed half-frame length would return shifted words at the longer lengths.

Values with only the MSB set and values with every bit except the MSB set expose a reversed bit order or an off-by-one in the count. Left and right words differ throughout, so a channel swap shows up at once.

The bench also applies a reset after nonzero samples have been delivered. A design that missed clearing its outputs would keep showing the old pair.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef struct packed {
    logic shiftEn;   // shift the current bit into the word register
    logic takeNext;  // captured word includes the current bit
    logic capLeft;   // store the word as the left sample
    logic capRight;  // store the word as right and publish the pair
  } sarx_strobe_t;
endpackage

// File: rtl/sarx_ctrl.sv
module sarx_ctrl
  import sarx_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bitClkIn,
  input  logic         frameClkIn,
  input  logic         dataIn,
  input  logic         modeFwd,
  output sarx_strobe_t strb,
  output logic         dataBit,
  output logic         lrLevel
);
  localparam int CNT_W = $clog2(W + 1);

  logic [SYNC-1:0] bckSh, lrSh, datSh;
  logic bckS, lrS, datS, bckD;
  logic seenBit, lrPrev;
  logic [CNT_W-1:0] bitCnt;
  logic bitRise, startEdge;

  always_ff @(posedge clk) begin
    if (rst) begin
      bckSh <= '0;
      lrSh  <= '0;
      datSh <= '0;
    end else begin
      bckSh <= {bckSh[SYNC-2:0], bitClkIn};
      lrSh  <= {lrSh[SYNC-2:0], frameClkIn};
      datSh <= {datSh[SYNC-2:0], dataIn};
    end
  end

  assign bckS = bckSh[SYNC-1];
  assign lrS  = lrSh[SYNC-1];
  assign datS = datSh[SYNC-1];

  assign bitRise   = bckS & ~bckD;
  assign startEdge = bitRise & (~seenBit | (lrS != lrPrev));

  always_ff @(posedge clk) begin
    if (rst) begin
      bckD    <= 1'b0;
      seenBit <= 1'b0;
      lrPrev  <= 1'b0;
      bitCnt  <= CNT_W'(W);
    end else begin
      bckD <= bckS;
      if (bitRise) begin
        seenBit <= 1'b1;
        lrPrev  <= lrS;
        if (startEdge)
          bitCnt <= CNT_W'(1);
        else if (bitCnt < CNT_W'(W))
          bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    strb = '0;
    strb.shiftEn = bitRise;
    if (modeFwd) begin
      if (bitRise && !startEdge && bitCnt == CNT_W'(W - 1)) begin
        strb.takeNext = 1'b1;
        strb.capLeft  = lrS;
        strb.capRight = ~lrS;
      end
    end else begin
      if (startEdge && seenBit) begin
        strb.capLeft  = lrPrev;
        strb.capRight = ~lrPrev;
      end
    end
  end

  assign dataBit = datS;
  assign lrLevel = lrS;
endmodule

// File: rtl/sarx_dpath.sv
module sarx_dpath
  import sarx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  sarx_strobe_t strb,
  input  logic         dataBit,
  output logic [W-1:0] leftOut,
  output logic [W-1:0] rightOut,
  output logic         validOut
);
  logic [W-1:0] shReg, leftHold, word;

  assign word = strb.takeNext ? {shReg[W-2:0], dataBit} : shReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg    <= '0;
      leftHold <= '0;
      leftOut  <= '0;
      rightOut <= '0;
      validOut <= 1'b0;
    end else begin
      if (strb.shiftEn)
        shReg <= {shReg[W-2:0], dataBit};
      if (strb.capLeft)
        leftHold <= word;
      validOut <= strb.capRight;
      if (strb.capRight) begin
        leftOut  <= leftHold;
        rightOut <= word;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bitClkIn,
  input  logic         frameClkIn,
  input  logic         dataIn,
  input  logic         modeFwd,
  output logic [W-1:0] leftOut,
  output logic [W-1:0] rightOut,
  output logic         validOut
);
  sarx_strobe_t strb;
  logic dataBit;
  logic lrLevel;

  sarx_ctrl #(.W(W), .SYNC(SYNC)) u_ctrl (
    .clk(clk), .rst(rst), .bitClkIn(bitClkIn), .frameClkIn(frameClkIn),
    .dataIn(dataIn), .modeFwd(modeFwd), .strb(strb), .dataBit(dataBit),
    .lrLevel(lrLevel)
  );

  sarx_dpath #(.W(W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .dataBit(dataBit),
    .leftOut(leftOut), .rightOut(rightOut), .validOut(validOut)
  );
endmodule

// File: rtl/sarx_chk.sv
module sarx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         modeFwd,
  input logic         lrLevel,
  input logic [W-1:0] leftOut,
  input logic [W-1:0] rightOut,
  input logic         validOut
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!validOut && leftOut == '0 && rightOut == '0));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> ($stable(leftOut) && $stable(rightOut)));

  // R3, R5: forward packing publishes while the right half-frame is running
  assert_fwd_right_R3: assert property (@(posedge clk) disable iff (rst)
    (validOut && $past(modeFwd)) |-> !$past(lrLevel));

  // R3, R4: backward packing publishes once the left half-frame has begun
  assert_bwd_left_R4: assert property (@(posedge clk) disable iff (rst)
    (validOut && !$past(modeFwd)) |-> $past(lrLevel));
endmodule

bind serial_audio_rx sarx_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .modeFwd(modeFwd), .lrLevel(lrLevel),
  .leftOut(leftOut), .rightOut(rightOut), .validOut(validOut)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitClkIn = 1'b0;
  logic frameClkIn = 1'b1;
  logic dataIn = 1'b0;
  logic modeFwd = 1'b0;
  logic [15:0] leftOut, rightOut;
  logic validOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  bit done = 0;

  always #10 clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rst(rst), .bitClkIn(bitClkIn), .frameClkIn(frameClkIn),
    .dataIn(dataIn), .modeFwd(modeFwd), .leftOut(leftOut),
    .rightOut(rightOut), .validOut(validOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bitTick(input logic lvl, input logic b);
    frameClkIn = lvl;
    dataIn = b;
    repeat (3) @(negedge clk);
    bitClkIn = 1'b1;
    repeat (3) @(negedge clk);
    bitClkIn = 1'b0;
  endtask

  // unused slots carry the inverted word so misalignment is visible
  task automatic sendHalf(input logic lvl, input logic [15:0] w, input int slots);
    for (int i = 0; i < slots; i++) begin
      logic b;
      b = ~w[15 - (i % 16)];
      if (modeFwd && i < 16) b = w[15 - i];
      if (!modeFwd && i >= slots - 16) b = w[15 - (i - (slots - 16))];
      bitTick(lvl, b);
    end
  endtask

  task automatic sendFrame(input logic [15:0] l, input logic [15:0] r, input int slots);
    expQ.push_back({l, r});
    sendHalf(1'b1, l, slots);
    sendHalf(1'b0, r, slots);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset left", {16'h0, leftOut}, 32'h0);
    check("R1 reset right", {16'h0, rightOut}, 32'h0);
    check("R1 reset valid", {31'h0, validOut}, 32'h0);
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (!rst && validOut) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R7: actual unexpected valid %h/%h expected none", leftOut, rightOut);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check("R2 R3 R4 R5 R6 left", {16'h0, leftOut}, {16'h0, e[31:16]});
        check("R2 R3 R4 R5 R6 right", {16'h0, rightOut}, {16'h0, e[15:0]});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // backward packed, R4 with R6 lengths 32/48/64 per frame
    modeFwd = 1'b0;
    doReset();
    sendFrame(16'h8000, 16'h7FFF, 16);
    sendFrame(16'hA5A5, 16'h5A5A, 24);
    sendFrame(16'h1234, 16'hFEDC, 32);
    sendFrame(16'hFFFF, 16'h0001, 16);
    bitTick(1'b1, 1'b0);   // start of next left half flushes the right word
    bitTick(1'b1, 1'b1);
    repeat (10) @(negedge clk);
    check("R7 backward all delivered", expQ.size(), 0);

    // R1: mid-stream reset clears nonzero outputs
    modeFwd = 1'b1;
    frameClkIn = 1'b1;
    doReset();

    // forward packed, R5 with R6 lengths
    sendFrame(16'h0001, 16'h8000, 16);
    sendFrame(16'hC3C3, 16'h3C3C, 32);
    sendFrame(16'h7FFF, 16'hFFFE, 24);
    sendFrame(16'h0F0F, 16'hF0F0, 32);
    repeat (10) @(negedge clk);
    check("R7 forward all delivered", expQ.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule